// File: doc/BRIEF.md
# Multi-Cycle Fetch-Decode-Execute Core

This block is a small 8-bit processor core. It runs each instruction as a visible chain of register transfers through a program counter (PC), a memory address register (MAR), a memory data register (MDR) and an instruction register (IR). Program fetch and data access share one 8-bit memory bus. A side-band output, `bus_prog`, tells the surrounding memory whether the current access goes to program space or to data space. Instructions are 16-bit words, so the core reads each one as two byte transfers, low byte first, and assembles the word in IR.

The core knows four operations: load an immediate into an upper register, add two registers, read an I/O location into a register, and store a register to a 16-bit data address. The store carries its address in a second instruction word. Every other word runs as a no-op. A 32-entry by 8-bit register file and a two-flag status register (carry, zero) hold all architectural state. The flags appear on an output port.

The memory answers combinationally. `bus_din` must be valid during the cycle in which `bus_rd` is high, and the core captures it at the closing clock edge.

Top module: `fdx_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_rd` and `bus_wr` are low and `flags` is 0. Every register-file entry reads as zero. The first bus access is a program read of byte address 0, one cycle after reset ends.
- R2: Each instruction word at word address P is read as two program-space reads in back-to-back cycles: byte 2P, which is the low half, then byte 2P+1. The PC then points at word P+1.
- R3: An instruction that starts in cycle t has a fixed timing. A load or an add occupies 5 cycles, and so does an unknown word. An I/O read occupies 7 cycles and issues its data read in cycle t+5. A store occupies 9 cycles and writes in cycle t+8. The first instruction after reset starts in cycle 0.
- R4: Load immediate `1110 KKKK dddd KKKK` writes the byte formed by the two K fields, high field first, into register 16+d. For example, 0xE709 loads 0x79 into r16.
- R5: I/O read `10110 AA ddddd AAAA` issues a data-space read (`bus_prog`=0) at address {AA,AAAA}, which is always below 64, and writes the returned byte into register d. For example, 0xB18A reads address 0x0A into r24.
- R6: Add `0000 11rd dddd rrrr` writes (Rd+Rr) mod 256 into Rd. Here d={bit8,bits7:4} and r={bit9,bits3:0}. Carry (`flags[0]`) is set when the 9-bit sum exceeds 0xFF. Zero (`flags[1]`) is set when the 8-bit result is 0x00.
- R7: The flags change only as the result of an add. Loads, I/O reads, stores and unknown words leave them as they were.
- R8: Store `1001 001d dddd 0000`, followed by an address word, writes register d to that 16-bit address with `bus_wr`=1 and `bus_prog`=0. The PC moves past both words.
- R9: A word that matches none of the four patterns changes no register and no flag. The only effect is that the PC advances by one word.
- R10: `bus_rd` and `bus_wr` are never high together. A write cycle is always followed by a cycle with no bus access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | output | 16 | Byte address of the current access |
| bus_rd | output | 1 | Read strobe; data captured at the end of the cycle |
| bus_wr | output | 1 | Write strobe |
| bus_prog | output | 1 | 1 = program space, 0 = data/I-O space |
| bus_din | input | 8 | Read data from memory |
| bus_dout | output | 8 | Write data to memory |
| flags | output | 2 | Status: bit 1 zero, bit 0 carry |

## Verification
The register file can only be seen through stores. A wrong register index, a missed write, or a second operand word that is not skipped therefore shows up only later, when the affected register reaches the bus. The bench builds random programs that mix all four operations with non-matching words. At the end of each program it stores every one of the 32 registers to its own address. A bench-side model of the instruction set predicts each stored value, the flags, the I/O address and the exact cycle of every access. Directed programs also force an add that wraps to exactly zero, an add that yields 0xFF with no carry, and flag persistence across unknown words and I/O reads.

// File: rtl/fdx_pkg.sv
package fdx_pkg;

   typedef enum logic [3:0] {
      SQ_FADDR,
      SQ_FLO,
      SQ_FHI,
      SQ_LDIR,
      SQ_DEC,
      SQ_IORD,
      SQ_IOWB,
      SQ_OPLO,
      SQ_OPHI,
      SQ_OPMAR,
      SQ_STWR
   } seq_e;

   typedef enum logic [2:0] {
      OP_NOP,
      OP_LDI,
      OP_ADD,
      OP_IN,
      OP_STS
   } op_e;

   typedef struct packed {
      op_e        op;
      logic [4:0] rd;
      logic [4:0] rr;
      logic [7:0] imm;
      logic [5:0] io;
   } dec_t;

   localparam logic [3:0] PAT_LDI = 4'b1110;
   localparam logic [5:0] PAT_ADD = 6'b000011;
   localparam logic [4:0] PAT_IN  = 5'b10110;
   localparam logic [6:0] PAT_STS = 7'b1001001;

endpackage

// File: rtl/fdx_decode.sv
module fdx_decode
   import fdx_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] ir,
   output dec_t              dec
);

   initial begin
      word_w_chk: assert (WORD_W == 16);
   end

   always_comb begin
      dec     = '0;
      dec.op  = OP_NOP;
      if (ir[15:12] == PAT_LDI) begin
         dec.op  = OP_LDI;
         dec.rd  = {1'b1, ir[7:4]};
         dec.imm = {ir[11:8], ir[3:0]};
      end else if (ir[15:10] == PAT_ADD) begin
         dec.op = OP_ADD;
         dec.rd = {ir[8], ir[7:4]};
         dec.rr = {ir[9], ir[3:0]};
      end else if (ir[15:11] == PAT_IN) begin
         dec.op = OP_IN;
         dec.rd = ir[8:4];
         dec.io = {ir[10:9], ir[3:0]};
      end else if (ir[15:9] == PAT_STS && ir[3:0] == 4'b0000) begin
         dec.op = OP_STS;
         dec.rd = ir[8:4];
      end
   end

endmodule

// File: rtl/fdx_alu.sv
module fdx_alu #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] sum,
   output logic              carry,
   output logic              zero
);

   logic [DATA_W:0] wide;

   always_comb begin
      wide  = {1'b0, opa} + {1'b0, opb};
      sum   = wide[DATA_W-1:0];
      carry = wide[DATA_W];
      zero  = (wide[DATA_W-1:0] == '0);
   end

   // R6
   always_comb begin
      if (carry) begin
         carry_wrap_chk: assert (sum < opa);
      end
   end

endmodule

// File: rtl/fdx_regfile.sv
module fdx_regfile #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 32,
   parameter bit RST_EN   = 1'b1,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ra,
   input  logic [IDX_W-1:0]  rb,
   output logic [DATA_W-1:0] qa,
   output logic [DATA_W-1:0] qb
);

   logic [NUM_REGS*DATA_W-1:0] flat;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = we && (waddr == IDX_W'(i));
      if (RST_EN) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (hit) q <= wdata;
         end
      end
      assign flat[i*DATA_W +: DATA_W] = q;
   end

   assign qa = flat[ra*DATA_W +: DATA_W];
   assign qb = flat[rb*DATA_W +: DATA_W];

endmodule

// File: rtl/fdx_core.sv
module fdx_core
   import fdx_pkg::*;
#(
   parameter int PC_W     = 14,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 16,
   parameter int NUM_REGS = 32,
   parameter bit RF_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              bus_prog,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic [1:0]        flags
);

   localparam int REG_AW = $clog2(NUM_REGS);
   localparam int WORD_W = 2 * DATA_W;
   localparam int IO_LIM = 64;

   initial begin
      data_w_chk: assert (DATA_W == 8);
      addr_w_chk: assert (ADDR_W == 16);
      regs_chk:   assert (NUM_REGS == 32);
      pc_w_chk:   assert (PC_W >= 2 && PC_W < ADDR_W);
   end

   seq_e              state;
   logic [PC_W-1:0]   pc;
   logic [ADDR_W-1:0] mar;
   logic [DATA_W-1:0] mdr;
   logic [WORD_W-1:0] ir;
   logic [DATA_W-1:0] opr;
   logic              c_flag;
   logic              z_flag;

   dec_t              dec;
   logic [DATA_W-1:0] rf_qa;
   logic [DATA_W-1:0] rf_qb;
   logic              rf_we;
   logic [REG_AW-1:0] rf_waddr;
   logic [DATA_W-1:0] rf_wdata;
   logic [DATA_W-1:0] alu_sum;
   logic              alu_c;
   logic              alu_z;

   fdx_decode #(.WORD_W(WORD_W)) i_decode (
      .ir  (ir),
      .dec (dec)
   );

   fdx_regfile #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .RST_EN   (RF_RESET)
   ) i_regfile (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .waddr (rf_waddr),
      .wdata (rf_wdata),
      .ra    (dec.rd),
      .rb    (dec.rr),
      .qa    (rf_qa),
      .qb    (rf_qb)
   );

   fdx_alu #(.DATA_W(DATA_W)) i_alu (
      .opa   (rf_qa),
      .opb   (rf_qb),
      .sum   (alu_sum),
      .carry (alu_c),
      .zero  (alu_z)
   );

   // register-file write port
   always_comb begin
      rf_we    = 1'b0;
      rf_waddr = dec.rd;
      rf_wdata = mdr;
      if (state == SQ_DEC && dec.op == OP_LDI) begin
         rf_we    = 1'b1;
         rf_wdata = dec.imm;
      end else if (state == SQ_DEC && dec.op == OP_ADD) begin
         rf_we    = 1'b1;
         rf_wdata = alu_sum;
      end else if (state == SQ_IOWB) begin
         rf_we    = 1'b1;
      end
   end

   // bus strobes
   always_comb begin
      bus_addr = mar;
      bus_rd   = 1'b0;
      bus_wr   = 1'b0;
      bus_prog = 1'b0;
      bus_dout = '0;
      unique case (state)
         SQ_FLO, SQ_FHI, SQ_OPLO, SQ_OPHI: begin
            bus_rd   = 1'b1;
            bus_prog = 1'b1;
         end
         SQ_IORD: bus_rd = 1'b1;
         SQ_STWR: begin
            bus_wr   = 1'b1;
            bus_dout = rf_qa;
         end
         default: ;
      endcase
   end

   assign flags = {z_flag, c_flag};

   // register-transfer sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_FADDR;
         pc     <= '0;
         mar    <= '0;
         mdr    <= '0;
         ir     <= '0;
         opr    <= '0;
         c_flag <= 1'b0;
         z_flag <= 1'b0;
      end else begin
         unique case (state)
            SQ_FADDR: begin
               mar   <= ADDR_W'({pc, 1'b0});
               pc    <= pc + 1'b1;
               state <= SQ_FLO;
            end
            SQ_FLO: begin
               mdr   <= bus_din;
               mar   <= mar + 1'b1;
               state <= SQ_FHI;
            end
            SQ_FHI: begin
               ir[DATA_W-1:0] <= mdr;
               mdr            <= bus_din;
               state          <= SQ_LDIR;
            end
            SQ_LDIR: begin
               ir[WORD_W-1:DATA_W] <= mdr;
               state               <= SQ_DEC;
            end
            SQ_DEC: begin
               unique case (dec.op)
                  OP_ADD: begin
                     c_flag <= alu_c;
                     z_flag <= alu_z;
                     state  <= SQ_FADDR;
                  end
                  OP_IN: begin
                     mar   <= ADDR_W'(dec.io);
                     state <= SQ_IORD;
                  end
                  OP_STS: begin
                     mar   <= ADDR_W'({pc, 1'b0});
                     pc    <= pc + 1'b1;
                     state <= SQ_OPLO;
                  end
                  default: state <= SQ_FADDR;
               endcase
            end
            SQ_IORD: begin
               mdr   <= bus_din;
               state <= SQ_IOWB;
            end
            SQ_IOWB: state <= SQ_FADDR;
            SQ_OPLO: begin
               mdr   <= bus_din;
               mar   <= mar + 1'b1;
               state <= SQ_OPHI;
            end
            SQ_OPHI: begin
               opr   <= mdr;
               mdr   <= bus_din;
               state <= SQ_OPMAR;
            end
            SQ_OPMAR: begin
               mar   <= {mdr, opr};
               state <= SQ_STWR;
            end
            SQ_STWR: state <= SQ_FADDR;
            default: state <= SQ_FADDR;
         endcase
      end
   end

   // R2
   lo_hi_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_prog && !bus_addr[0]) |=>
      (bus_rd && bus_prog && bus_addr == $past(bus_addr) + 16'd1));

   // R5
   io_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_prog) |-> (bus_addr < ADDR_W'(IO_LIM)));

   // R10
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   // R10
   wr_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> (!bus_wr && !bus_rd));

   // R8
   wr_data_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> !bus_prog);

   // R7
   flags_only_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flags) |-> $past(state == SQ_DEC && dec.op == OP_ADD));

endmodule

// File: tb/test_fdx_core.sv
`timescale 1ns/1ps
module test_fdx_core;

   localparam int ROM_WORDS = 256;
   localparam int MAXEV     = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr;
   logic        bus_rd;
   logic        bus_wr;
   logic        bus_prog;
   logic [7:0]  bus_din;
   logic [7:0]  bus_dout;
   logic [1:0]  flags;

   always #2 clk = ~clk;

   fdx_core i_fdx_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .bus_prog (bus_prog),
      .bus_din  (bus_din),
      .bus_dout (bus_dout),
      .flags    (flags)
   );

   logic [15:0] rom [0:ROM_WORDS-1];
   logic [7:0]  salt;

   function automatic logic [7:0] io_val(input logic [5:0] a, input logic [7:0] s);
      return (8'(a) * 8'd29 + 8'h3B) ^ s;
   endfunction

   logic [15:0] rom_word;
   assign rom_word = rom[bus_addr[8:1]];
   assign bus_din  = bus_prog ? (bus_addr[0] ? rom_word[15:8] : rom_word[7:0])
                              : io_val(bus_addr[5:0], salt);

   int errors = 0;
   int checks = 0;
   int cyc    = 0;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // golden model state
   logic [7:0]  gold [0:31];
   logic        gc, gz;
   int          pcw, tt;
   logic [15:0] st_addr [0:MAXEV-1];
   logic [7:0]  st_data [0:MAXEV-1];
   logic [1:0]  st_flg  [0:MAXEV-1];
   int          st_cyc  [0:MAXEV-1];
   logic [5:0]  io_addr [0:MAXEV-1];
   int          io_cyc  [0:MAXEV-1];
   int          st_cnt, io_cnt, st_seen, io_seen;

   task automatic start_prog();
      for (int i = 0; i < ROM_WORDS; i++) rom[i] = 16'h0000;
      for (int i = 0; i < 32; i++) gold[i] = 8'h00;
      gc = 1'b0; gz = 1'b0;
      pcw = 0; tt = 0; st_cnt = 0; io_cnt = 0;
      salt = 8'($urandom);
   endtask

   task automatic em_ldi(input logic [3:0] d, input logic [7:0] k);
      rom[pcw] = {4'b1110, k[7:4], d, k[3:0]};
      gold[16 + int'(d)] = k;
      pcw += 1; tt += 5;
   endtask

   task automatic em_add(input logic [4:0] d, input logic [4:0] r);
      logic [8:0] s;
      rom[pcw] = {6'b000011, r[4], d[4], d[3:0], r[3:0]};
      s = {1'b0, gold[d]} + {1'b0, gold[r]};
      gold[d] = s[7:0];
      gc = s[8];
      gz = (s[7:0] == 8'h00);
      pcw += 1; tt += 5;
   endtask

   task automatic em_in(input logic [4:0] d, input logic [5:0] a);
      rom[pcw] = {5'b10110, a[5:4], d, a[3:0]};
      io_addr[io_cnt] = a;
      io_cyc[io_cnt]  = tt + 5;
      io_cnt++;
      gold[d] = io_val(a, salt);
      pcw += 1; tt += 7;
   endtask

   task automatic em_sts(input logic [4:0] d, input logic [15:0] a);
      rom[pcw]     = {7'b1001001, d, 4'b0000};
      rom[pcw + 1] = a;
      st_addr[st_cnt] = a;
      st_data[st_cnt] = gold[d];
      st_flg[st_cnt]  = {gz, gc};
      st_cyc[st_cnt]  = tt + 8;
      st_cnt++;
      pcw += 2; tt += 9;
   endtask

   task automatic em_raw(input logic [15:0] w);
      rom[pcw] = w;
      pcw += 1; tt += 5;
   endtask

   function automatic bit known(input logic [15:0] w);
      return (w[15:12] == 4'b1110) || (w[15:10] == 6'b000011) ||
             (w[15:11] == 5'b10110) || (w[15:9] == 7'b1001001 && w[3:0] == 4'h0);
   endfunction

   // observe the bus away from the active edge
   always @(negedge clk) begin
      if (rst_n && cyc >= 1) begin
         if (cyc == 1)
            chk(bus_rd && bus_prog && bus_addr == 16'h0000, "R1 first fetch at 0",
                int'(bus_addr), 0);
         if (bus_wr) begin
            if (st_seen < st_cnt) begin
               chk(bus_addr == st_addr[st_seen], "R8 store address", int'(bus_addr), int'(st_addr[st_seen]));
               chk(bus_dout == st_data[st_seen], "R4/R5/R6/R9 stored register", int'(bus_dout), int'(st_data[st_seen]));
               chk(flags == st_flg[st_seen], "R6/R7 flags at store", int'(flags), int'(st_flg[st_seen]));
               chk(cyc == st_cyc[st_seen], "R3 store cycle", cyc, st_cyc[st_seen]);
               chk(!bus_prog, "R8 store in data space", int'(bus_prog), 0);
            end else begin
               chk(1'b0, "R8 unexpected store", int'(bus_addr), -1);
            end
            st_seen++;
         end
         if (bus_rd && !bus_prog) begin
            if (io_seen < io_cnt) begin
               chk(bus_addr == 16'(io_addr[io_seen]), "R5 io address", int'(bus_addr), int'(io_addr[io_seen]));
               chk(cyc == io_cyc[io_seen], "R3 io read cycle", cyc, io_cyc[io_seen]);
            end else begin
               chk(1'b0, "R5 unexpected io read", int'(bus_addr), -1);
            end
            io_seen++;
         end
      end
   end

   task automatic run_prog(input string tag);
      @(negedge clk);
      rst_n = 1'b0;
      st_seen = 0;
      io_seen = 0;
      repeat (3) @(negedge clk);
      chk(!bus_rd && !bus_wr && flags == 2'b00, "R1 idle in reset",
          int'({bus_rd, bus_wr, flags}), 0);
      rst_n = 1'b1;
      while (cyc < tt + 12) @(negedge clk);
      chk(st_seen == st_cnt, {"R8 store count ", tag}, st_seen, st_cnt);
      chk(io_seen == io_cnt, {"R5 io read count ", tag}, io_seen, io_cnt);
   endtask

   initial begin
      void'($urandom(32'd20240611));

      // directed: encodings, wrap to zero, 0xFF without carry, flag persistence
      start_prog();
      rom[pcw] = 16'hB18A;                    // R5: r24 <- io[0x0A]
      io_addr[io_cnt] = 6'h0A; io_cyc[io_cnt] = tt + 5; io_cnt++;
      gold[24] = io_val(6'h0A, salt);
      pcw += 1; tt += 7;
      em_sts(5'd24, 16'h0100);
      rom[pcw] = 16'hE709;                    // R4: r16 <- 0x79
      gold[16] = 8'h79;
      pcw += 1; tt += 5;
      em_sts(5'd16, 16'h0101);
      em_ldi(4'd0, 8'hFF);
      em_ldi(4'd1, 8'h01);
      em_add(5'd16, 5'd17);                   // R6: 0xFF+1 -> 0, C=1 Z=1
      em_sts(5'd16, 16'h0102);
      em_raw(16'hFFFF);                       // R9: unknown word
      em_in(5'd3, 6'h3F);                     // R7: flags kept
      em_sts(5'd16, 16'h0103);
      em_ldi(4'd2, 8'h80);
      em_ldi(4'd3, 8'h7F);
      em_add(5'd18, 5'd19);                   // R6: 0xFF, C=0 Z=0
      em_sts(5'd18, 16'hFFFF);
      em_add(5'd20, 5'd20);                   // R6: 0+0 -> Z=1 C=0
      em_sts(5'd20, 16'h0000);
      em_sts(5'd3, 16'h8000);
      for (int i = 0; i < 32; i++) em_sts(5'(i), 16'h4000 + 16'(i));  // R1 cleared regs
      run_prog("directed");

      // random programs
      for (int round = 0; round < 6; round++) begin
         start_prog();
         for (int n = 0; n < 40; n++) begin
            int kind;
            kind = int'($urandom_range(0, 9));
            if (kind < 3)      em_ldi(4'($urandom), 8'($urandom));
            else if (kind < 6) em_add(5'($urandom), 5'($urandom));
            else if (kind < 7) em_in(5'($urandom), 6'($urandom));
            else if (kind < 9) em_sts(5'($urandom), 16'($urandom));
            else begin
               logic [15:0] w;
               w = 16'($urandom);
               while (known(w)) w = 16'($urandom);
               em_raw(w);
            end
         end
         for (int i = 0; i < 32; i++) em_sts(5'(i), 16'h8000 + 16'(i));
         run_prog("random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R3 watchdog expired actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule